// File: doc/BRIEF.md
# Daisy-Chain Token Readout Controller

This controller runs one front-end readout chip through the four phases of each cycle: acquisition, conversion, readout and idle. Several such chips share one data bus. Which chip may drive that bus is settled by a token passed along a daisy chain, starting at the first chip. A chip that holds the token and has recorded events starts its local serializer and drives the bus until the serializer reports that it is done. It then passes the token on and powers down. A chip with no recorded events passes the token on at once and never drives the bus.

The phase commands (acquisition start, conversion start, readout start) come from a shared controller. The event count is taken when readout starts. The serializer and the analog power switches are outside this block. The block only supplies the serializer start pulse and the power-down request.

Top module: `ring_readout_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the outputs after that edge are token_out=0, bus_en=0, ser_start=0, pwr_down=1 (the chip is idle).
- R2: Phases advance only in the order idle/done → acquisition → conversion → readout. acq_start moves any phase to acquisition. conv_start has an effect only in acquisition and ro_start only in conversion. token_in has an effect only in readout. pwr_down is 0 in acquisition, conversion and readout.
- R3: In readout, token_in with a nonzero captured event count raises bus_en in the next cycle, with ser_start high for exactly that one cycle.
- R4: bus_en stays high until a ser_done is seen. In the cycle after it, bus_en is 0 and token_out is high for exactly one cycle. token_in during this time has no effect.
- R5: In readout, token_in with a zero captured event count raises token_out in the next cycle for one cycle. bus_en and ser_start stay 0.
- R6: After the token_out pulse the chip is idle (pwr_down=1). Further token_in or ser_done has no effect until the next acq_start.
- R7: acq_start clears the token state. In the next cycle bus_en=0 and token_out=0, even when the chip was driving the bus.
- R8: The event count is sampled at the edge where ro_start moves conversion into readout. Later changes of evt_count do not alter the send or skip decision.
- R9: bus_en and token_out are never high together, and ser_start is only high together with bus_en.
- R10: ser_done outside the bus-driving state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_start | input | 1 | Start acquisition (also clears token state) |
| conv_start | input | 1 | Start A/D conversion |
| ro_start | input | 1 | Start readout phase |
| token_in | input | 1 | Token from previous chip in the chain |
| evt_count | input | CNT_W | Events recorded by this chip |
| ser_done | input | 1 | Local serializer finished sending |
| token_out | output | 1 | One-cycle token pulse to next chip |
| bus_en | output | 1 | This chip drives the shared data bus |
| ser_start | output | 1 | One-cycle serializer start pulse |
| pwr_down | output | 1 | Request to power down the analog part |

## Verification
A wrong phase register shows up as pwr_down being wrong in the cycle after the command. It can also show as a token_in that is accepted or ignored wrongly, which appears one cycle later as an unexpected bus_en or token_out. A wrong token state shows at once on the next edge: a missing or stretched ser_start or token_out pulse, or bus_en overlapping the handoff. A wrong captured event flag turns a send into a skip, or a skip into a send, and this is visible in the cycle right after token_in.

// File: rtl/ring_ro_pkg.sv
// Shared types for the daisy-chain readout controller.
// Assumes: both state encodings stay internal to the block.
package ring_ro_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACQ,
        PH_CONV,
        PH_READ,
        PH_DONE
    } phase_t;

    typedef enum logic [1:0] {
        TK_WAIT,
        TK_SEND,
        TK_PASS
    } tok_t;
endpackage

// File: rtl/ro_phase_seq.sv
// Phase sequencer: steps idle -> acquisition -> conversion -> readout -> done.
// Assumes: acq_start has priority over every other command; hand_off marks
// the cycle in which this chip forwards the token.
module ro_phase_seq
    import ring_ro_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   acq_start,
    input  logic   conv_start,
    input  logic   ro_start,
    input  logic   hand_off,
    output phase_t phase
);
    phase_t phase_nx;

    // Next phase: only legal commands in the current phase take effect
    always_comb begin
        phase_nx = phase;
        if (acq_start) begin
            phase_nx = PH_ACQ;
        end else begin
            case (phase)
                PH_ACQ:  if (conv_start) phase_nx = PH_CONV;
                PH_CONV: if (ro_start)   phase_nx = PH_READ;
                PH_READ: if (hand_off)   phase_nx = PH_DONE;
                default: phase_nx = phase;
            endcase
        end
    end

    // Phase register with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end
endmodule

// File: rtl/ro_evt_snap.sv
// Event snapshot: records whether the chip holds any event at readout entry.
// Assumes: evt_count is stable at the edge where ro_start is accepted.
module ro_evt_snap
    import ring_ro_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic             acq_start,
    input  logic             ro_start,
    input  logic [CNT_W-1:0] evt_count,
    output logic             has_ev
);
    logic capture;

    // Capture happens exactly on the conversion -> readout transition
    always_comb capture = (phase == PH_CONV) && ro_start && !acq_start;

    // Nonzero-count flag register
    always_ff @(posedge clk) begin
        if (!rst_n)       has_ev <= 1'b0;
        else if (capture) has_ev <= |evt_count;
    end
endmodule

// File: rtl/ro_token_unit.sv
// Token unit: accepts the token in readout, either sends (serializer) or
// skips, then forwards the token as a one-cycle pulse.
// Assumes: clear (acquisition start) aborts any send in progress.
module ro_token_unit
    import ring_ro_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rd_active,
    input  logic token_in,
    input  logic has_ev,
    input  logic ser_done,
    output tok_t tstate,
    output logic ser_start
);
    tok_t tstate_nx;
    logic take;

    // Token accepted only while waiting inside the readout phase
    always_comb take = (tstate == TK_WAIT) && rd_active && token_in;

    // Next token state
    always_comb begin
        tstate_nx = tstate;
        if (clear) begin
            tstate_nx = TK_WAIT;
        end else begin
            case (tstate)
                TK_WAIT: if (take) tstate_nx = has_ev ? TK_SEND : TK_PASS;
                TK_SEND: if (ser_done) tstate_nx = TK_PASS;
                default: tstate_nx = TK_WAIT;
            endcase
        end
    end

    // Token state register and serializer start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tstate    <= TK_WAIT;
            ser_start <= 1'b0;
        end else begin
            tstate    <= tstate_nx;
            ser_start <= !clear && take && has_ev;
        end
    end
endmodule

// File: rtl/ring_readout_ctrl.sv
// Per-chip readout controller for a token daisy chain on a shared data bus.
// Assumes: token_out of chip k feeds token_in of chip k+1; chip 0 gets its
// token from the shared controller after every chip has seen ro_start.
module ring_readout_ctrl
    import ring_ro_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_start,
    input  logic             conv_start,
    input  logic             ro_start,
    input  logic             token_in,
    input  logic [CNT_W-1:0] evt_count,
    input  logic             ser_done,
    output logic             token_out,
    output logic             bus_en,
    output logic             ser_start,
    output logic             pwr_down
);
    phase_t phase;
    tok_t   tstate;
    logic   has_ev;
    logic   hand_off;

    // Handoff is the single cycle the token unit spends forwarding
    always_comb hand_off = (tstate == TK_PASS);

    ro_phase_seq i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_start  (acq_start),
        .conv_start (conv_start),
        .ro_start   (ro_start),
        .hand_off   (hand_off),
        .phase      (phase)
    );

    ro_evt_snap #(.CNT_W(CNT_W)) i_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .acq_start (acq_start),
        .ro_start  (ro_start),
        .evt_count (evt_count),
        .has_ev    (has_ev)
    );

    ro_token_unit i_tok (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acq_start),
        .rd_active (phase == PH_READ),
        .token_in  (token_in),
        .has_ev    (has_ev),
        .ser_done  (ser_done),
        .tstate    (tstate),
        .ser_start (ser_start)
    );

    // Output decode from the registered states
    always_comb begin
        token_out = hand_off;
        bus_en    = (tstate == TK_SEND);
        pwr_down  = (phase == PH_IDLE) || (phase == PH_DONE);
    end
endmodule

// File: rtl/ring_readout_ctrl_chk.sv
// Port-level checker for ring_readout_ctrl, attached by bind.
module ring_readout_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic acq_start,
    input logic ser_done,
    input logic token_out,
    input logic bus_en,
    input logic ser_start,
    input logic pwr_down
);
    // R9
    bus_tok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && token_out));

    // R9
    start_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> bus_en);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_start);

    // R4
    tok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);

    // R4
    done_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && ser_done && !acq_start) |=> (token_out && !bus_en));

    // R6
    idle_after_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (token_out && !acq_start) |=> pwr_down);

    // R7
    acq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> (!bus_en && !token_out && !pwr_down));
endmodule

bind ring_readout_ctrl ring_readout_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_start (acq_start),
    .ser_done  (ser_done),
    .token_out (token_out),
    .bus_en    (bus_en),
    .ser_start (ser_start),
    .pwr_down  (pwr_down)
);

// File: tb/test_ring_readout_ctrl.sv
// Scoreboard bench: cyc() drives one cycle of inputs and queues the output
// expected after the next rising edge; the monitor pops and compares.
module test_ring_readout_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acq = 1'b0, conv = 1'b0, ro = 1'b0, tin = 1'b0, sdone = 1'b0;
    logic [7:0] evt = 8'd0;
    logic       token_out, bus_en, ser_start, pwr_down;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    ring_readout_ctrl #(.CNT_W(8)) i_ring_readout_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_start  (acq),
        .conv_start (conv),
        .ro_start   (ro),
        .token_in   (tin),
        .evt_count  (evt),
        .ser_done   (sdone),
        .token_out  (token_out),
        .bus_en     (bus_en),
        .ser_start  (ser_start),
        .pwr_down   (pwr_down)
    );

    // exp bits: {token_out, bus_en, ser_start, pwr_down}
    task automatic cyc(input bit r, a, c, o, t, d, input [7:0] n,
                       input [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = r; acq = a; conv = c; ro = o; tin = t; sdone = d; evt = n;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cycles++;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if ({token_out, bus_en, ser_start, pwr_down} !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", it.tag,
                             {token_out, bus_en, ser_start, pwr_down}, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(0,0,0,0,0,0,0, 4'b0001, "R1 reset");
        cyc(0,0,0,0,0,0,0, 4'b0001, "R1 reset hold");
        cyc(1,0,0,0,0,0,0, 4'b0001, "R1 idle after reset");
        // R2 out-of-order commands in idle
        cyc(1,0,0,1,0,0,3, 4'b0001, "R2 ro_start in idle");
        cyc(1,0,0,0,1,0,3, 4'b0001, "R2 token in idle");
        cyc(1,0,1,0,0,0,3, 4'b0001, "R2 conv_start in idle");
        cyc(1,1,0,0,0,0,3, 4'b0000, "R2 acq_start");
        cyc(1,0,0,1,0,0,3, 4'b0000, "R2 ro_start in acq");
        cyc(1,0,0,0,1,0,3, 4'b0000, "R2 token in acq");
        cyc(1,0,1,0,0,0,3, 4'b0000, "R2 conv_start");
        cyc(1,0,0,0,1,0,3, 4'b0000, "R2 token in conv");
        cyc(1,0,0,1,0,0,3, 4'b0000, "R2 ro_start");
        // R8 count changes after capture; R3 send
        cyc(1,0,0,0,0,0,0, 4'b0000, "R8 wait");
        cyc(1,0,0,0,1,0,0, 4'b0110, "R3 R8 send start");
        cyc(1,0,0,0,0,0,0, 4'b0100, "R3 start pulse one cycle");
        cyc(1,0,0,0,1,0,0, 4'b0100, "R4 token ignored in send");
        cyc(1,0,0,0,0,0,0, 4'b0100, "R4 bus held");
        cyc(1,0,0,0,0,1,0, 4'b1000, "R4 handoff");
        cyc(1,0,0,0,0,0,0, 4'b0001, "R6 idle after handoff");
        cyc(1,0,0,0,1,0,7, 4'b0001, "R6 token ignored");
        cyc(1,0,0,0,0,1,7, 4'b0001, "R10 ser_done in done");
        // Round 2: zero events, count raised after capture
        cyc(1,1,0,0,0,0,0, 4'b0000, "R2 acq from done");
        cyc(1,0,1,0,0,0,0, 4'b0000, "R2 conv");
        cyc(1,0,0,1,0,0,0, 4'b0000, "R8 capture zero");
        cyc(1,0,0,0,0,1,5, 4'b0000, "R10 ser_done while waiting");
        cyc(1,0,0,0,1,0,5, 4'b1000, "R5 R8 skip");
        cyc(1,0,0,0,0,0,5, 4'b0001, "R5 pulse one cycle");
        // Round 3: abort by acq_start
        cyc(1,1,0,0,0,0,1, 4'b0000, "R7 acq");
        cyc(1,0,1,0,0,0,1, 4'b0000, "R7 conv");
        cyc(1,0,0,1,0,0,1, 4'b0000, "R7 ro");
        cyc(1,0,0,0,1,0,1, 4'b0110, "R3 send");
        cyc(1,1,0,0,0,0,1, 4'b0000, "R7 acq clears send");
        cyc(1,0,0,0,0,1,1, 4'b0000, "R7 R10 no handoff");
        cyc(1,0,1,0,0,0,0, 4'b0000, "R7 conv");
        cyc(1,0,0,1,0,0,0, 4'b0000, "R7 ro zero");
        cyc(1,0,0,0,1,0,0, 4'b1000, "R5 skip after abort");
        cyc(1,0,0,0,0,0,0, 4'b0001, "R6 done");
        // Round 4: long send then reset mid-send
        cyc(1,1,0,0,0,0,200, 4'b0000, "R2 acq");
        cyc(1,0,1,0,0,0,200, 4'b0000, "R2 conv");
        cyc(1,0,0,1,0,0,200, 4'b0000, "R8 capture");
        cyc(1,0,0,0,1,0,200, 4'b0110, "R3 send");
        for (int i = 0; i < 6; i++)
            cyc(1,0,0,0,0,0,200, 4'b0100, "R4 long hold");
        cyc(1,0,0,0,0,1,200, 4'b1000, "R4 handoff");
        cyc(1,0,0,0,0,0,200, 4'b0001, "R6 done");
        cyc(1,1,0,0,0,0,9, 4'b0000, "R2 acq");
        cyc(1,0,1,0,0,0,9, 4'b0000, "R2 conv");
        cyc(1,0,0,1,0,0,9, 4'b0000, "R2 ro");
        cyc(1,0,0,0,1,0,9, 4'b0110, "R3 send");
        cyc(0,0,0,0,0,0,9, 4'b0001, "R1 reset mid-send");
        cyc(1,0,0,0,1,1,9, 4'b0001, "R1 token ignored after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule